// File: doc/BRIEF.md
# DTMF Delayed-Steering Guard Timer

This block sits behind a dual-tone detector. It takes the detector's raw tone-present flag (early steering) and the 4-bit code of the decoded digit. It produces a validated steering output and a held copy of the digit. The output rises only after the tone flag has stayed high for an uninterrupted accept period. It then stays high until the flag has stayed low for an uninterrupted release period. Short dropouts inside one digit are therefore bridged, and short bursts of noise are never reported as digits.

Both periods are counted in ticks of a prescaler that divides the system clock. With the default settings the clock is 4.194304 MHz and the prescaler divides by 4096, which gives a 1024 Hz tick. Each period is 31 ticks, about 30.3 ms. That value lies between the 20 ms that must be rejected and the 40 ms that must be accepted, for tone bursts and for inter-digit gaps alike. The code present at the cycle the output rises is captured into a holding register. A power-down input forces the block inactive.

Top module: `dtmf_guard_timer`

## Requirements
- R1: After reset `delaySteer` is 0 and `digitOut` is 0.
- R2: With `delaySteer` low and `powerDown` low, `delaySteer` goes high at the clock edge that is the N_P-th consecutive edge sampling `earlySteer` high, where N_P = PRESENT_TICKS*TICK_DIV. It stays low at every earlier edge.
- R3: A burst of `earlySteer` high lasting N_P-1 edges or fewer never raises `delaySteer`. The accept timer then restarts from zero.
- R4: On the edge where `delaySteer` rises, `digitOut` takes the value of `digitIn`. At every other edge `digitOut` keeps its value, whatever `digitIn` does, including after the fall, until the next rise or power-down.
- R5: With `delaySteer` high, it goes low at the N_A-th consecutive edge sampling `earlySteer` low, where N_A = ABSENT_TICKS*TICK_DIV.
- R6: A dropout of `earlySteer` lasting N_A-1 edges or fewer leaves `delaySteer` high. The release timer is cleared when the flag returns, so a second dropout of the same length is also bridged.
- R7: An edge that samples `powerDown` high drives `delaySteer` low, clears `digitOut` to 0 and clears both timers. While `powerDown` stays high, `delaySteer` stays low even with `earlySteer` high.
- R8: After `powerDown` falls with `earlySteer` held high, `delaySteer` rises only after a full N_P consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4.194304 MHz nominal |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 1 | High forces the block inactive |
| earlySteer | input | 1 | Raw tone-present flag from the detector |
| digitIn | input | CODE_W | Decoded digit code from the detector |
| delaySteer | output | 1 | Validated steering output |
| digitOut | output | CODE_W | Digit code held since the last rise |

## Verification
The assertions assume that `earlySteer`, `powerDown` and `digitIn` are synchronous to `clk` and change only between edges. The bench meets this by driving every input on the falling edge. The properties relate each change of `delaySteer` to the flag level and the power-down level sampled one edge earlier. The bench shortens TICK_DIV and gives the two periods different lengths, so a swapped limit shows up as a wrong cycle. Each burst and each gap it applies is placed exactly one edge below or at its threshold.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic clrTimer;   // zero prescaler and tick counter
    logic runTimer;   // advance prescaler by one cycle
    logic absentSel;  // select the release limit instead of the accept limit
    logic loadDigit;  // capture the incoming code
    logic clrDigit;   // clear the held code
  } guardStrobes_t;

  typedef enum logic [0:0] {
    ST_QUIET = 1'b0,
    ST_HELD  = 1'b1
  } guardState_e;

endpackage

// File: rtl/dtmf_guard_datapath.sv
module dtmf_guard_datapath
  import dtmf_guard_pkg::*;
#(
  parameter int TICK_DIV      = 4096,
  parameter int PRESENT_TICKS = 31,
  parameter int ABSENT_TICKS  = 31,
  parameter int CODE_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [CODE_W-1:0] digitIn,
  output logic              timerDone,
  output logic [CODE_W-1:0] digitOut
);

  localparam int MAX_TICKS = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
  localparam int PRE_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TICK_W    = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST     = PRE_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] PRESENT_LAST = TICK_W'(PRESENT_TICKS - 1);
  localparam logic [TICK_W-1:0] ABSENT_LAST  = TICK_W'(ABSENT_TICKS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] tickLimit;
  logic              preLast;
  logic              tickLast;

  assign preLast   = (preCnt == PRE_LAST);
  assign tickLimit = strobes.absentSel ? ABSENT_LAST : PRESENT_LAST;
  assign tickLast  = (tickCnt == tickLimit);
  assign timerDone = preLast && tickLast;

  // Prescaler and tick counter of the guard period
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrTimer) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobes.runTimer) begin
      if (preLast) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // Held digit code
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrDigit) begin
      digitOut <= '0;
    end else if (strobes.loadDigit) begin
      digitOut <= digitIn;
    end
  end

  // A running timer never passes the limit of the selected phase (R2, R5)
  p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runTimer |-> (tickCnt <= tickLimit));

  // A cleared timer starts the next period from zero (R3, R6)
  p_timer_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrTimer |=> (preCnt == '0) && (tickCnt == '0));

endmodule

// File: rtl/dtmf_guard_control.sv
module dtmf_guard_control
  import dtmf_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          powerDown,
  input  logic          earlySteer,
  input  logic          timerDone,
  output guardStrobes_t strobes,
  output logic          delaySteer
);

  guardState_e state;
  guardState_e nextState;
  logic        mismatch;

  // The timer runs while the raw flag disagrees with the validated output
  assign mismatch   = earlySteer != (state == ST_HELD);
  assign delaySteer = (state == ST_HELD);

  always_comb begin
    strobes           = '0;
    strobes.absentSel = (state == ST_HELD);
    nextState         = state;
    if (powerDown) begin
      strobes.clrTimer = 1'b1;
      strobes.clrDigit = 1'b1;
      nextState        = ST_QUIET;
    end else if (mismatch) begin
      if (timerDone) begin
        strobes.clrTimer  = 1'b1;
        strobes.loadDigit = (state == ST_QUIET);
        nextState         = (state == ST_QUIET) ? ST_HELD : ST_QUIET;
      end else begin
        strobes.runTimer = 1'b1;
      end
    end else begin
      strobes.clrTimer = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_QUIET;
    else       state <= nextState;
  end

  p_pd_forces_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !delaySteer);

  p_rise_needs_tone_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delaySteer) |-> ($past(earlySteer) && !$past(powerDown)));

  p_fall_needs_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(delaySteer) |-> (!$past(earlySteer) || $past(powerDown)));

  p_single_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.runTimer && strobes.clrTimer));

endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer
  import dtmf_guard_pkg::*;
#(
  parameter int TICK_DIV      = 4096,
  parameter int PRESENT_TICKS = 31,
  parameter int ABSENT_TICKS  = 31,
  parameter int CODE_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDown,
  input  logic              earlySteer,
  input  logic [CODE_W-1:0] digitIn,
  output logic              delaySteer,
  output logic [CODE_W-1:0] digitOut
);

  guardStrobes_t strobes;
  logic          timerDone;

  dtmf_guard_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .powerDown  (powerDown),
    .earlySteer (earlySteer),
    .timerDone  (timerDone),
    .strobes    (strobes),
    .delaySteer (delaySteer)
  );

  dtmf_guard_datapath #(
    .TICK_DIV      (TICK_DIV),
    .PRESENT_TICKS (PRESENT_TICKS),
    .ABSENT_TICKS  (ABSENT_TICKS),
    .CODE_W        (CODE_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .digitIn   (digitIn),
    .timerDone (timerDone),
    .digitOut  (digitOut)
  );

  // Held code is frozen while the output stays high (R4)
  p_digit_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (delaySteer && $past(delaySteer)) |-> $stable(digitOut));

endmodule

// File: tb/dtmf_guard_timer_test.sv
module dtmf_guard_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int PT  = 5;
  localparam int AT  = 3;
  localparam int NP  = PT * DIV;  // 20 edges
  localparam int NA  = AT * DIV;  // 12 edges

  typedef struct {
    int         cyc;
    logic       steer;
    logic [3:0] digit;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerDown = 1'b0;
  logic       earlySteer = 1'b0;
  logic [3:0] digitIn = 4'h0;
  logic       delaySteer;
  logic [3:0] digitOut;

  int       cycCount = 0;
  int       checks = 0;
  int       errors = 0;
  expItem_t expQ[$];

  dtmf_guard_timer #(
    .TICK_DIV(DIV), .PRESENT_TICKS(PT), .ABSENT_TICKS(AT), .CODE_W(4)
  ) uut (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .earlySteer(earlySteer),
    .digitIn(digitIn), .delaySteer(delaySteer), .digitOut(digitOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycCount <= cycCount + 1;

  task automatic expectAt(input int cyc, input logic steer, input logic [3:0] digit,
                          input string tag);
    expItem_t it;
    it.cyc = cyc; it.steer = steer; it.digit = digit; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops items due this cycle and compares
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cycCount) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (it.cyc != cycCount) begin
        errors++;
        $display("FAIL %s: missed sample cycle actual=%0d expected=%0d", it.tag, cycCount, it.cyc);
      end else if (delaySteer !== it.steer || digitOut !== it.digit) begin
        errors++;
        $display("FAIL %s: cycle %0d actual steer=%b digit=%h expected steer=%b digit=%h",
                 it.tag, cycCount, delaySteer, digitOut, it.steer, it.digit);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    int t;
    waitCycles(3);
    rstN = 1'b1;
    expectAt(cycCount + 1, 1'b0, 4'h0, "R1 reset state");
    waitCycles(3);

    // R3: burst one edge short of the accept period
    t = cycCount; earlySteer = 1'b1; digitIn = 4'h5;
    expectAt(t + NP - 1, 1'b0, 4'h0, "R3 short burst");
    waitCycles(NP - 1);
    earlySteer = 1'b0;
    expectAt(t + NP + 2, 1'b0, 4'h0, "R3 short burst after");
    waitCycles(5);

    // R2/R4: accepted tone and digit capture
    t = cycCount; earlySteer = 1'b1; digitIn = 4'h9;
    expectAt(t + NP - 1, 1'b0, 4'h0, "R2 before accept");
    expectAt(t + NP,     1'b1, 4'h9, "R2 R4 accept and capture");
    waitCycles(NP + 1);
    digitIn = 4'h3;
    expectAt(t + NP + 5, 1'b1, 4'h9, "R4 input change ignored");
    waitCycles(6);

    // R6: two dropouts one edge short of the release period
    for (int k = 0; k < 2; k++) begin
      t = cycCount; earlySteer = 1'b0;
      expectAt(t + NA - 1, 1'b1, 4'h9, "R6 dropout bridged");
      waitCycles(NA - 1);
      earlySteer = 1'b1;
      expectAt(t + NA + 2, 1'b1, 4'h9, "R6 held after dropout");
      waitCycles(4);
    end

    // R5: full gap releases; code retained
    t = cycCount; earlySteer = 1'b0;
    expectAt(t + NA - 1, 1'b1, 4'h9, "R5 before release");
    expectAt(t + NA,     1'b0, 4'h9, "R5 R4 release keeps code");
    waitCycles(NA + 3);

    // R7: power-down while held
    t = cycCount; earlySteer = 1'b1; digitIn = 4'h6;
    expectAt(t + NP, 1'b1, 4'h6, "R2 second digit");
    waitCycles(NP + 2);
    t = cycCount; powerDown = 1'b1;
    expectAt(t + 1,  1'b0, 4'h0, "R7 forced low and cleared");
    expectAt(t + NP + 5, 1'b0, 4'h0, "R7 stays low with tone");
    waitCycles(NP + 8);

    // R8: release power-down with tone held
    t = cycCount; powerDown = 1'b0; digitIn = 4'hC;
    expectAt(t + NP - 1, 1'b0, 4'h0, "R8 full period needed");
    expectAt(t + NP,     1'b1, 4'hC, "R8 accept after power-down");
    waitCycles(NP + 3);

    while (expQ.size() > 0) waitCycles(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule